// File: doc/BRIEF.md
# Segmented Panorama Scale-Step Generator

This block drives the horizontal resampling step of a video postscaler so that a line can be stretched nonlinearly: the middle of the picture keeps its proportions while the edges are widened. The line is cut into five segments by four programmable boundary positions and a line length. Inside each segment the running step moves by a signed slope of its own once per output double-pixel. This gives a piecewise-linear step profile across the line.

A line-start strobe reloads the step from the base value and restarts the segment walk. Each double-pixel enable then updates the step, the segment index and a phase accumulator. The accumulator reports how many source pixels the interpolator must advance and the fractional phase left over. The step is held in unsigned fixed point with 12 integer bits and 3 fractional bits, so `step_out` = base × 8 at line start.

The control is a three-state machine:
- **IDLE**: after reset, waiting for the first line.
- **RUN**: stepping through a line.
- **HOLD**: line length reached; everything frozen.

Its transitions:
- **START**: any state to RUN, on a line-start strobe with a non-zero line length.
- **START_EMPTY**: any state to HOLD, on a line-start strobe with a zero line length.
- **LINE_END**: RUN to HOLD, on the double-pixel that reaches the line length.

Top module: `pano_step_gen`

## Requirements
- R1: After reset, `step_out`, `seg_idx`, `src_adv` and `phase_frac` are all 0.
- R2: A line-start strobe loads `step_out` with base×8 and clears `phase_frac`, `src_adv` and the double-pixel count. It sets `seg_idx` to the number of boundaries equal to 0. The strobe takes priority over a double-pixel enable in the same cycle.
- R3: A base value below 1024 is loaded as 1024, so `step_out` = 8192.
- R4: With panorama enabled, each double-pixel in RUN adds to `step_out` the increment of the segment in force before that double-pixel. Increment k sits in `seg_incs[9k+8:9k]` as 9-bit two's complement, where one LSB is one unit of `step_out`.
- R5: With panorama disabled, `step_out` keeps the loaded base value for the whole line.
- R6: After the n-th double-pixel of a line, `seg_idx` equals the number of boundaries that are ≤ 2n. Boundary k+1 sits in `seg_bounds[12k+11:12k]`. When boundaries are equal, the zero-length segment between them is skipped in that same cycle.
- R7: `step_out` saturates within 8192..32767 and never wraps.
- R8: The double-pixel with 2n ≥ line length still updates the outputs. After it, double-pixel enables change neither `step_out`, `seg_idx` nor `phase_frac`, and they force `src_adv` to 0 until the next line start.
- R9: On each double-pixel in RUN, t = `phase_frac` + 2×`step_out` is formed from the values before the update. `src_adv` becomes t>>15 and `phase_frac` becomes t mod 32768.
- R10: In a cycle with neither a line-start strobe nor a double-pixel enable, all outputs hold their values.
- R11: A line-start strobe in the middle of a line restarts the line as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Line-start strobe |
| dp_en | input | 1 | Double-pixel enable |
| pano_en | input | 1 | Panorama slope enable |
| base_step | input | 12 | Base scaler value (1024..4095) |
| seg_bounds | input | 48 | Four boundaries, 12 bits each, in output pixels |
| line_len | input | 12 | Line length in output pixels |
| seg_incs | input | 45 | Five signed 9-bit increments |
| step_out | output | 16 | Current step, Q12.3 with one guard bit |
| seg_idx | output | 3 | Current segment 0..4 |
| src_adv | output | 2 | Source pixels advanced in the last double-pixel |
| phase_frac | output | 15 | Fractional source phase |

## Verification
A segment index that advances at the wrong double-pixel shows at `seg_idx` in that same cycle. From the next double-pixel onward it also shows as a wrong slope on `step_out`, so a boundary off by one double-pixel surfaces within two enables. A step that wraps instead of saturating, or a state that fails to freeze at the line end, changes `step_out` on the very next enable. Phase errors appear at `src_adv` and `phase_frac` on the double-pixel that causes them, because both are formed from the step value seen before the update.

// File: rtl/pano_pkg.sv
package pano_pkg;
    localparam int BASE_W  = 12;
    localparam int FRAC_W  = 3;
    localparam int STEP_W  = BASE_W + FRAC_W + 1;   // one guard bit
    localparam int INC_W   = 9;
    localparam int POS_W   = 12;
    localparam int NSEG    = 5;
    localparam int NBND    = NSEG - 1;
    localparam int SEG_W   = $clog2(NSEG + 1);
    localparam int PH_W    = BASE_W + FRAC_W;
    localparam int ADV_W   = 2;
    localparam int STEP_MIN = 1024 << FRAC_W;
    localparam int STEP_MAX = (1 << PH_W) - 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HOLD = 2'd2
    } pano_state_e;
endpackage

// File: rtl/pano_seg_locator.sv
module pano_seg_locator
    import pano_pkg::*;
#(
    parameter int N_B  = NBND,
    parameter int PW   = POS_W,
    parameter int SW   = SEG_W
) (
    input  logic [PW:0]       pos,
    input  logic [N_B*PW-1:0] bounds,
    output logic [SW-1:0]     seg
);
    logic [N_B-1:0] passed;

    for (genvar k = 0; k < N_B; k++) begin : g_cmp
        assign passed[k] = ({1'b0, bounds[k*PW +: PW]} <= pos);
    end

    always_comb begin
        seg = '0;
        for (int k = 0; k < N_B; k++) begin
            seg = seg + SW'(passed[k]);
        end
    end
endmodule

// File: rtl/pano_step_sat.sv
module pano_step_sat
    import pano_pkg::*;
#(
    parameter int SW = STEP_W,
    parameter int IW = INC_W
) (
    input  logic [SW-1:0] step_in,
    input  logic [IW-1:0] inc,
    output logic [SW-1:0] step_sat
);
    localparam int XW = SW + 2;
    logic signed [XW-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, step_in}) + $signed({{(XW-IW){inc[IW-1]}}, inc});
        if (sum < XW'(STEP_MIN))
            step_sat = SW'(STEP_MIN);
        else if (sum > XW'(STEP_MAX))
            step_sat = SW'(STEP_MAX);
        else
            step_sat = sum[SW-1:0];
    end
endmodule

// File: rtl/pano_phase_acc.sv
module pano_phase_acc
    import pano_pkg::*;
#(
    parameter int PW = PH_W,
    parameter int AW = ADV_W
) (
    input  logic [PW-1:0] phase_in,
    input  logic [PW-1:0] step,
    output logic [AW-1:0] adv,
    output logic [PW-1:0] phase_out
);
    logic [PW+AW-1:0] total;

    always_comb begin
        total     = {{AW{1'b0}}, phase_in} + {{(AW-1){1'b0}}, step, 1'b0};
        adv       = total[PW +: AW];
        phase_out = total[PW-1:0];
    end
endmodule

// File: rtl/pano_step_gen.sv
module pano_step_gen
    import pano_pkg::*;
#(
    parameter int BW   = BASE_W,
    parameter int PW   = POS_W,
    parameter int IW   = INC_W,
    parameter int NS   = NSEG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start,
    input  logic                  dp_en,
    input  logic                  pano_en,
    input  logic [BW-1:0]         base_step,
    input  logic [(NS-1)*PW-1:0]  seg_bounds,
    input  logic [PW-1:0]         line_len,
    input  logic [NS*IW-1:0]      seg_incs,
    output logic [STEP_W-1:0]     step_out,
    output logic [SEG_W-1:0]      seg_idx,
    output logic [ADV_W-1:0]      src_adv,
    output logic [PH_W-1:0]       phase_frac
);
    localparam int NB = NS - 1;

    pano_state_e state_q, state_d;

    logic [PW-1:0]     cnt_q;
    logic [PW-1:0]     cnt_inc;
    logic [PW:0]       pos_sel;
    logic [SEG_W-1:0]  seg_found;
    logic [IW-1:0]     inc_cur;
    logic [STEP_W-1:0] step_next;
    logic [STEP_W-1:0] base_q123;
    logic [ADV_W-1:0]  adv_next;
    logic [PH_W-1:0]   phase_next;
    logic              reach_end;
    logic              empty_line;

    assign cnt_inc    = cnt_q + 1'b1;
    assign pos_sel    = line_start ? '0 : {cnt_inc, 1'b0};
    assign reach_end  = ({cnt_inc, 1'b0} >= {1'b0, line_len});
    assign empty_line = (line_len == '0);
    assign inc_cur    = seg_incs[seg_idx*IW +: IW];
    assign base_q123  = (base_step < BW'(1024))
                      ? STEP_W'(STEP_MIN)
                      : {1'b0, base_step, {FRAC_W{1'b0}}};

    pano_seg_locator #(.N_B(NB), .PW(PW), .SW(SEG_W)) u_loc (
        .pos    (pos_sel),
        .bounds (seg_bounds),
        .seg    (seg_found)
    );

    pano_step_sat #(.SW(STEP_W), .IW(IW)) u_sat (
        .step_in  (step_out),
        .inc      (inc_cur),
        .step_sat (step_next)
    );

    pano_phase_acc #(.PW(PH_W), .AW(ADV_W)) u_ph (
        .phase_in  (phase_frac),
        .step      (step_out[PH_W-1:0]),
        .adv       (adv_next),
        .phase_out (phase_next)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (line_start) begin
            state_d = empty_line ? S_HOLD : S_RUN;          // START / START_EMPTY
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_RUN:  if (dp_en && reach_end) state_d = S_HOLD; // LINE_END
                S_HOLD: state_d = S_HOLD;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            step_out   <= '0;
            seg_idx    <= '0;
            src_adv    <= '0;
            phase_frac <= '0;
        end else if (line_start) begin
            cnt_q      <= '0;
            step_out   <= base_q123;
            seg_idx    <= seg_found;
            src_adv    <= '0;
            phase_frac <= '0;
        end else if (dp_en) begin
            unique case (state_q)
                S_RUN: begin
                    cnt_q      <= cnt_inc;
                    seg_idx    <= seg_found;
                    src_adv    <= adv_next;
                    phase_frac <= phase_next;
                    if (pano_en) step_out <= step_next;
                end
                S_HOLD:  src_adv <= '0;
                S_IDLE:  ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pano_step_gen_chk.sv
module pano_step_gen_chk
    import pano_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              dp_en,
    input logic              pano_en,
    input logic [STEP_W-1:0] step_out,
    input logic [SEG_W-1:0]  seg_idx,
    input logic [ADV_W-1:0]  src_adv,
    input logic [PH_W-1:0]   phase_frac
);
    assert_seg_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seg_idx <= SEG_W'(NSEG - 1));

    assert_seg_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> seg_idx >= $past(seg_idx));

    assert_step_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_out != '0) |-> (step_out >= STEP_W'(STEP_MIN) && step_out <= STEP_W'(STEP_MAX)));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (phase_frac == '0 && src_adv == '0 && step_out >= STEP_W'(STEP_MIN)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !dp_en) |=> ($stable(step_out) && $stable(seg_idx)
                                     && $stable(phase_frac) && $stable(src_adv)));

    assert_pano_off_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !pano_en) |=> $stable(step_out));
endmodule

bind pano_step_gen pano_step_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .dp_en      (dp_en),
    .pano_en    (pano_en),
    .step_out   (step_out),
    .seg_idx    (seg_idx),
    .src_adv    (src_adv),
    .phase_frac (phase_frac)
);

// File: tb/sim_pano_step_gen.sv
module sim_pano_step_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        dp_en = 1'b0;
    logic        pano_en = 1'b0;
    logic [11:0] base_step = 12'd2048;
    logic [47:0] seg_bounds = '0;
    logic [11:0] line_len = 12'd100;
    logic [44:0] seg_incs = '0;
    logic [15:0] step_out;
    logic [2:0]  seg_idx;
    logic [1:0]  src_adv;
    logic [14:0] phase_frac;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pano_step_gen u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .dp_en(dp_en),
        .pano_en(pano_en), .base_step(base_step), .seg_bounds(seg_bounds),
        .line_len(line_len), .seg_incs(seg_incs), .step_out(step_out),
        .seg_idx(seg_idx), .src_adv(src_adv), .phase_frac(phase_frac)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_bounds(input int b1, input int b2, input int b3, input int b4);
        seg_bounds = {12'(b4), 12'(b3), 12'(b2), 12'(b1)};
    endtask

    task automatic set_incs(input int i0, input int i1, input int i2, input int i3, input int i4);
        seg_incs = {9'(i4), 9'(i3), 9'(i2), 9'(i1), 9'(i0)};
    endtask

    task automatic start_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic dp_pulse();
        @(negedge clk); dp_en = 1'b1;
        @(negedge clk); dp_en = 1'b0;
    endtask

    function automatic int sat(input int v);
        if (v < 8192) return 8192;
        if (v > 32767) return 32767;
        return v;
    endfunction

    task automatic t_reset();
        check("R1 step", int'(step_out), 0);
        check("R1 seg", int'(seg_idx), 0);
        check("R1 adv", int'(src_adv), 0);
        check("R1 phase", int'(phase_frac), 0);
    endtask

    task automatic t_pano_off();
        pano_en = 1'b0; base_step = 12'd3000; line_len = 12'd40;
        set_bounds(4, 8, 12, 16); set_incs(8, 16, -8, 40, 24);
        start_line();
        check("R2 base load", int'(step_out), 24000);
        for (int k = 0; k < 6; k++) dp_pulse();
        check("R5 flat step", int'(step_out), 24000);
        @(negedge clk); @(negedge clk);
        check("R10 idle hold", int'(step_out), 24000);
    endtask

    task automatic t_seg_walk();
        int inc[5] = '{8, 16, -8, 0, 24};
        int bnd[4] = '{4, 8, 12, 16};
        int step_e = 16384;
        int seg_e = 0;
        int ph_e = 0;
        int adv_e = 0;
        pano_en = 1'b1; base_step = 12'd2048; line_len = 12'd20;
        set_bounds(4, 8, 12, 16); set_incs(8, 16, -8, 0, 24);
        start_line();
        check("R2 seg at start", int'(seg_idx), 0);
        for (int n = 1; n <= 10; n++) begin
            int t;
            t = ph_e + 2 * step_e;
            adv_e = t >> 15; ph_e = t % 32768;
            step_e = sat(step_e + inc[seg_e]);
            seg_e = 0;
            for (int k = 0; k < 4; k++) if (bnd[k] <= 2 * n) seg_e++;
            dp_pulse();
            check("R4 step ramp", int'(step_out), step_e);
            check("R6 seg index", int'(seg_idx), seg_e);
            check("R9 phase", int'(phase_frac), ph_e);
            check("R9 advance", int'(src_adv), adv_e);
        end
        dp_pulse(); dp_pulse();
        check("R8 frozen step", int'(step_out), step_e);
        check("R8 frozen seg", int'(seg_idx), 4);
        check("R8 frozen phase", int'(phase_frac), ph_e);
        check("R8 adv zero", int'(src_adv), 0);
    endtask

    task automatic t_zero_len();
        pano_en = 1'b1; base_step = 12'd2048; line_len = 12'd40;
        set_bounds(0, 4, 4, 4); set_incs(100, 8, 16, 32, -16);
        start_line();
        check("R2 skip at start", int'(seg_idx), 1);
        dp_pulse();
        check("R4 seg1 inc", int'(step_out), 16392);
        dp_pulse();
        check("R6 skip equal", int'(seg_idx), 4);
        check("R4 seg1 inc again", int'(step_out), 16400);
        dp_pulse();
        check("R4 last seg inc", int'(step_out), 16384);
    endtask

    task automatic t_saturate();
        pano_en = 1'b1; line_len = 12'd40; set_bounds(100, 100, 100, 100);
        base_step = 12'd4095; set_incs(255, 0, 0, 0, 0);
        start_line();
        dp_pulse();
        check("R7 sat high", int'(step_out), 32767);
        dp_pulse();
        check("R7 sat high hold", int'(step_out), 32767);
        base_step = 12'd1024; set_incs(-256, 0, 0, 0, 0);
        start_line();
        dp_pulse();
        check("R7 sat low", int'(step_out), 8192);
        base_step = 12'd500;
        start_line();
        check("R3 base clamp", int'(step_out), 8192);
    endtask

    task automatic t_phase_restart();
        pano_en = 1'b0; base_step = 12'd3072; line_len = 12'd40;
        start_line();
        dp_pulse();
        check("R9 adv one", int'(src_adv), 1);
        check("R9 frac", int'(phase_frac), 16384);
        dp_pulse();
        check("R9 adv two", int'(src_adv), 2);
        check("R9 frac wrap", int'(phase_frac), 0);
        dp_pulse();
        base_step = 12'd2500;
        @(negedge clk); line_start = 1'b1; dp_en = 1'b1;
        @(negedge clk); line_start = 1'b0; dp_en = 1'b0;
        check("R11 restart step", int'(step_out), 20000);
        check("R11 restart phase", int'(phase_frac), 0);
        check("R11 restart adv", int'(src_adv), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pano_off();
        t_seg_walk();
        t_zero_len();
        t_saturate();
        t_phase_restart();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule